// File: doc/BRIEF.md
# Watchdog Timer with Pre-Reset Interrupt

This block is a programmable watchdog for a small byte-wide register bus. An internal counter advances on every system clock. When it reaches the timeout picked by a 2-bit select code, the block sets an interrupt flag and can raise an interrupt request. It then allows a fixed grace period. If software has not restarted the count by the end of that period and the watchdog is armed, the block issues a synchronous reset pulse to the rest of the chip.

Two control bits are write-protected by a timed-access gate: the arm bit and the restart bit. To open the gate, software writes AAh and then 55h to a key register on back-to-back cycles. One protected control write is then accepted within the next three clocks. Writes outside that window leave both bits alone. The interrupt-enable bit and the timeout select are not protected. The interrupt is meant to be serviced at vector 63h by the surrounding CPU. The CPU, the interrupt vectoring and the reset distribution are not part of this block.

Top module: `wdt_guard`

## Requirements
- R1: After reset, both outputs are low. The control register (address 0) reads 00h, the status register (address 1) reads 00h and the key register (address 2) reads 00h.
- R2: The control field bits 5:4 select the timeout. Code n gives 2^(LIMIT_BASE_LOG2 + n*LIMIT_STEP_LOG2) clocks: 2^17, 2^20, 2^23 or 2^26 at the defaults. The interrupt flag (status bit 0) becomes set exactly that many clocks after the edge that captured a restart.
- R3: A restart is control bit 0 written as 1 through an open gate. It clears the count. Given before the timeout, it holds off the interrupt. Given inside the grace period, it cancels the reset.
- R4: If the arm bit (control bit 1) is set, the reset pulse starts GRACE_CLKS clocks (default 512) after the interrupt timeout. If the arm bit is clear, no pulse is issued, the count returns to zero at that point and the timeout repeats.
- R5: The wdt_irq output is high while the interrupt flag and the interrupt-enable bit (control bit 2) are both set. The interrupt-enable bit is writable without unlocking.
- R6: Writing AAh and then 55h to the key register on consecutive cycles opens a window. A control write captured on any of the next 3 clock edges is accepted, and the first such write closes the window. Key register bit 0 reads 1 while the window is open. A gap between AAh and 55h opens no window.
- R7: A control write outside the window leaves the arm bit unchanged and does not restart the count. The select and interrupt-enable fields are still updated.
- R8: Status bit 0 is the interrupt flag and status bit 1 is the watchdog-reset cause flag. Each is cleared by writing 1 to its bit. A flag that is set and cleared in the same cycle stays set. The cause flag is set when the reset pulse starts.
- R9: The reset pulse lasts RST_PULSE_CLKS clocks (default 4). The count is zero during the pulse, and the arm bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| wdt_irq | output | 1 | Watchdog interrupt request |
| wdt_rst | output | 1 | Watchdog reset pulse, synchronous to clk |

## Verification
The bench times the interrupt and reset edges to the exact cycle after a restart.

- **Timing.** A counter that is off by one in either the timeout compare or the grace compare moves an edge by a cycle and is caught.
- **Restart in the grace period.** A restart given during the grace period must suppress the pulse. A design that ignores it would still reset the chip.
- **Unarmed expiry.** With the arm bit clear, the interrupt must reappear one full timeout plus grace later. A design that stalls the count would never interrupt again.
- **Unlock window edges.** The gate is probed at its third and fourth clock after unlocking, with a broken key sequence, and with a second write in one window. A window that is too long, too short or reusable would let stray code disarm the watchdog.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_KEY  = 2'd2,
    REG_NONE = 2'd3
  } wdt_reg_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  // control register bit positions
  localparam int CTRL_RESTART_BIT = 0;
  localparam int CTRL_ARM_BIT     = 1;
  localparam int CTRL_IE_BIT      = 2;
  localparam int CTRL_SEL_LSB     = 4;

  // status register bit positions
  localparam int STAT_IRQ_BIT   = 0;
  localparam int STAT_CAUSE_BIT = 1;

  // timeout length in clocks for a select code
  function automatic int unsigned wdt_limit(input logic [1:0] sel,
                                            input int unsigned base_log2,
                                            input int unsigned step_log2);
    return 32'd1 << (base_log2 + step_log2 * int'(sel));
  endfunction

  // counter width able to hold the longest timeout plus the grace period
  function automatic int unsigned wdt_cnt_width(input int unsigned base_log2,
                                                input int unsigned step_log2,
                                                input int unsigned grace);
    return $clog2(wdt_limit(2'b11, base_log2, step_log2) + grace) + 1;
  endfunction

endpackage

// File: rtl/wdt_access_gate.sv
module wdt_access_gate
  import wdt_guard_pkg::*;
#(
  parameter int WIN_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       prot_wr,
  output logic       unlocked
);

  localparam int WW = $clog2(WIN_CLKS + 1);

  logic          first_seen;
  logic [WW-1:0] win_cnt;
  logic          key_done;

  assign key_done = key_wr && first_seen && (key_data == KEY_SECOND);
  assign unlocked = (win_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_seen <= 1'b0;
    end else begin
      first_seen <= key_wr && (key_data == KEY_FIRST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (key_done) begin
      win_cnt <= WW'(WIN_CLKS);
    end else if (key_wr || prot_wr) begin
      win_cnt <= '0;
    end else if (unlocked) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_guard_pkg::*;
#(
  parameter int LIMIT_BASE_LOG2 = 17,
  parameter int LIMIT_STEP_LOG2 = 3,
  parameter int GRACE_CLKS      = 512,
  parameter int CW              = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic          restart,
  input  logic          hold,
  output logic [CW-1:0] cnt,
  output logic          irq_hit,
  output logic          rst_hit
);

  logic [CW-1:0] irq_mark;
  logic [CW-1:0] rst_mark;

  assign irq_mark = CW'(wdt_limit(sel, LIMIT_BASE_LOG2, LIMIT_STEP_LOG2) - 32'd1);
  assign rst_mark = CW'(wdt_limit(sel, LIMIT_BASE_LOG2, LIMIT_STEP_LOG2)
                        + 32'(GRACE_CLKS) - 32'd1);

  assign irq_hit = (cnt == irq_mark) && !restart && !hold;
  assign rst_hit = (cnt == rst_mark) && !restart && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || hold || rst_hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int RST_PULSE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);

  localparam int PW = $clog2(RST_PULSE_CLKS + 1);

  logic [PW-1:0] left;

  assign active = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (fire) begin
      left <= PW'(RST_PULSE_CLKS);
    end else if (active) begin
      left <= left - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int LIMIT_BASE_LOG2 = 17,
  parameter int LIMIT_STEP_LOG2 = 3,
  parameter int GRACE_CLKS      = 512,
  parameter int RST_PULSE_CLKS  = 4,
  parameter int UNLOCK_WIN_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_irq,
  output logic       wdt_rst
);

  localparam int CW = wdt_cnt_width(LIMIT_BASE_LOG2, LIMIT_STEP_LOG2, GRACE_CLKS);

  // named internal events
  logic          ctrl_wr;
  logic          stat_wr;
  logic          key_wr;
  logic          unlocked;
  logic          restart_evt;
  logic          irq_hit;
  logic          rst_hit;
  logic          rst_fire;
  logic          pulse_on;
  logic [CW-1:0] cnt;

  // register state
  logic       en_q;
  logic       ie_q;
  logic [1:0] sel_q;
  logic       irq_flag_q;
  logic       rst_flag_q;

  assign ctrl_wr     = bus_we && (wdt_reg_e'(bus_addr) == REG_CTRL);
  assign stat_wr     = bus_we && (wdt_reg_e'(bus_addr) == REG_STAT);
  assign key_wr      = bus_we && (wdt_reg_e'(bus_addr) == REG_KEY);
  assign restart_evt = ctrl_wr && unlocked && bus_wdata[CTRL_RESTART_BIT];
  assign rst_fire    = rst_hit && en_q;

  wdt_access_gate #(
    .WIN_CLKS (UNLOCK_WIN_CLKS)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .prot_wr  (ctrl_wr),
    .unlocked (unlocked)
  );

  wdt_counter #(
    .LIMIT_BASE_LOG2 (LIMIT_BASE_LOG2),
    .LIMIT_STEP_LOG2 (LIMIT_STEP_LOG2),
    .GRACE_CLKS      (GRACE_CLKS),
    .CW              (CW)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel_q),
    .restart (restart_evt),
    .hold    (pulse_on),
    .cnt     (cnt),
    .irq_hit (irq_hit),
    .rst_hit (rst_hit)
  );

  wdt_rst_pulse #(
    .RST_PULSE_CLKS (RST_PULSE_CLKS)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (rst_fire),
    .active (pulse_on)
  );

  // unprotected control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      sel_q <= 2'b00;
    end else if (ctrl_wr) begin
      ie_q  <= bus_wdata[CTRL_IE_BIT];
      sel_q <= bus_wdata[CTRL_SEL_LSB +: 2];
    end
  end

  // protected arm bit, cleared by a watchdog reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (rst_fire) begin
      en_q <= 1'b0;
    end else if (ctrl_wr && unlocked) begin
      en_q <= bus_wdata[CTRL_ARM_BIT];
    end
  end

  // sticky status flags, write 1 to clear, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag_q <= 1'b0;
      rst_flag_q <= 1'b0;
    end else begin
      if (irq_hit) begin
        irq_flag_q <= 1'b1;
      end else if (stat_wr && bus_wdata[STAT_IRQ_BIT]) begin
        irq_flag_q <= 1'b0;
      end
      if (rst_fire) begin
        rst_flag_q <= 1'b1;
      end else if (stat_wr && bus_wdata[STAT_CAUSE_BIT]) begin
        rst_flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    unique case (wdt_reg_e'(bus_addr))
      REG_CTRL: begin
        bus_rdata[CTRL_ARM_BIT]        = en_q;
        bus_rdata[CTRL_IE_BIT]         = ie_q;
        bus_rdata[CTRL_SEL_LSB +: 2]   = sel_q;
      end
      REG_STAT: begin
        bus_rdata[STAT_IRQ_BIT]   = irq_flag_q;
        bus_rdata[STAT_CAUSE_BIT] = rst_flag_q;
      end
      REG_KEY:  bus_rdata[0] = unlocked;
      REG_NONE: bus_rdata = 8'h00;
    endcase
  end

  assign wdt_irq = irq_flag_q && ie_q;
  assign wdt_rst = pulse_on;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CW = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          wdt_rst,
  input logic          unlocked,
  input logic          en_q,
  input logic          rst_flag_q,
  input logic          restart_evt,
  input logic [CW-1:0] cnt
);

  // R4: a pulse only starts when the watchdog was armed
  p_rst_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(en_q));

  // R8: cause flag is up when the pulse begins
  p_cause_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> rst_flag_q);

  // R9: arm bit is dropped by the watchdog reset
  p_arm_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> !en_q);

  // R9: count stays at zero for the whole pulse
  p_cnt_idle_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (cnt == '0));

  // R3: accepted restart zeroes the count on the next cycle
  p_restart_zeroes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (cnt == '0));

  // R6: the window only opens right after the second key byte
  p_unlock_after_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_we && bus_addr == 2'd2 && bus_wdata == 8'h55));

endmodule

bind wdt_guard wdt_guard_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .wdt_rst     (wdt_rst),
  .unlocked    (unlocked),
  .en_q        (en_q),
  .rst_flag_q  (rst_flag_q),
  .restart_evt (restart_evt),
  .cnt         (cnt)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;

  localparam int BASE  = 5;
  localparam int STEP  = 1;
  localparam int GRACE = 16;
  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdt_irq;
  logic       wdt_rst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    at;
    int    sig;     // 0: wdt_irq, 1: wdt_rst
    logic  val;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_guard #(
    .LIMIT_BASE_LOG2 (BASE),
    .LIMIT_STEP_LOG2 (STEP),
    .GRACE_CLKS      (GRACE),
    .RST_PULSE_CLKS  (PULSE),
    .UNLOCK_WIN_CLKS (3)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wdt_irq   (wdt_irq),
    .wdt_rst   (wdt_rst)
  );

  function automatic int tmo(input int sel);
    return 32 * (2 ** sel);  // 2^(BASE + STEP*sel) with BASE=5, STEP=1
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops scoreboard items at their cycle and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t it;
      logic got;
      it  = sb.pop_front();
      got = (it.sig == 0) ? wdt_irq : wdt_rst;
      if (it.at != cyc) check(8'hEE, 8'(it.at), {it.tag, " missed"});
      else check({7'd0, got}, {7'd0, it.val}, it.tag);
    end
  end

  task automatic expect_at(input int at, input int sig, input logic val, input string tag);
    exp_t it;
    it.at = at; it.sig = sig; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  // called at a negedge; returns at the next negedge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata, exp, tag);
  endtask

  task automatic unlock_wr(input logic [7:0] d);
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
    wr(2'd0, d);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, c1, c2, c3, c5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check({6'd0, wdt_rst, wdt_irq}, 8'h00, "R1 outputs");
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 status");
    rd(2'd2, 8'h00, "R1 key");

    // A: armed expiry, sel 00
    wr(2'd0, 8'h04);
    unlock_wr(8'h07);
    c0 = cyc;
    wr(2'd1, 8'h03);
    expect_at(c0 + tmo(0) - 1, 0, 1'b0, "R2 irq early");
    expect_at(c0 + tmo(0),     0, 1'b1, "R2 R5 irq at timeout");
    expect_at(c0 + tmo(0) + GRACE - 1, 1, 1'b0, "R4 rst early");
    expect_at(c0 + tmo(0) + GRACE,     1, 1'b1, "R4 rst start");
    expect_at(c0 + tmo(0) + GRACE + PULSE - 1, 1, 1'b1, "R9 rst last");
    expect_at(c0 + tmo(0) + GRACE + PULSE,     1, 1'b0, "R9 rst end");
    wait_until(c0 + tmo(0) + GRACE + PULSE + 3);
    rd(2'd1, 8'h03, "R8 flags after reset");
    rd(2'd0, 8'h04, "R9 arm cleared");
    wr(2'd1, 8'h03);
    rd(2'd1, 8'h00, "R8 w1c");

    // B: restart inside grace cancels reset, sel 01
    unlock_wr(8'h17);
    c1 = cyc;
    wr(2'd1, 8'h03);
    expect_at(c1 + tmo(1), 0, 1'b1, "R2 irq sel01");
    wait_until(c1 + tmo(1) + 6);
    unlock_wr(8'h17);
    c2 = cyc;
    wr(2'd1, 8'h03);
    expect_at(c1 + tmo(1) + GRACE, 1, 1'b0, "R3 reset cancelled");
    expect_at(c2 + tmo(1) - 1, 0, 1'b0, "R3 irq held off");
    expect_at(c2 + tmo(1),     0, 1'b1, "R3 irq after restart");
    wait_until(c2 + tmo(1) + 2);

    // C: locked write ignores arm and restart
    unlock_wr(8'h15);
    c3 = cyc;
    wr(2'd1, 8'h03);
    idle(10);
    wr(2'd0, 8'h17);
    rd(2'd0, 8'h14, "R7 arm unchanged");
    expect_at(c3 + tmo(1) - 1, 0, 1'b0, "R7 irq early");
    expect_at(c3 + tmo(1),     0, 1'b1, "R7 restart ignored");
    wait_until(c3 + tmo(1) + 2);

    // D: unlock window edges, sel 11
    unlock_wr(8'h35);
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
    rd(2'd2, 8'h01, "R6 key open");
    idle(2);
    wr(2'd0, 8'h37);
    rd(2'd0, 8'h36, "R6 third edge accepted");
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
    idle(3);
    wr(2'd0, 8'h35);
    rd(2'd0, 8'h36, "R6 fourth edge rejected");
    wr(2'd2, 8'hAA);
    idle(1);
    wr(2'd2, 8'h55);
    rd(2'd2, 8'h00, "R6 gap no unlock");
    wr(2'd0, 8'h35);
    rd(2'd0, 8'h36, "R6 gap write rejected");
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
    wr(2'd0, 8'h35);
    wr(2'd0, 8'h37);
    rd(2'd0, 8'h34, "R6 window consumed");

    // E: unarmed expiry repeats, interrupt gating
    wr(2'd0, 8'h00);
    unlock_wr(8'h01);
    c5 = cyc;
    wr(2'd1, 8'h03);
    expect_at(c5 + tmo(0), 0, 1'b0, "R5 irq masked");
    expect_at(c5 + tmo(0) + GRACE, 1, 1'b0, "R4 no reset unarmed");
    wait_until(c5 + tmo(0) + 2);
    rd(2'd1, 8'h01, "R5 flag set while masked");
    wait_until(c5 + tmo(0) + GRACE + 2);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h04);
    expect_at(c5 + 2 * tmo(0) + GRACE - 1, 0, 1'b0, "R4 wrap early");
    expect_at(c5 + 2 * tmo(0) + GRACE,     0, 1'b1, "R4 wrap repeats");
    wait_until(c5 + 2 * tmo(0) + GRACE + 2);
    rd(2'd1, 8'h01, "R4 no cause flag");

    wait (sb.size() == 0);
    idle(1);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule